// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block produces the digital reference code that the voltage loop of a boost power-factor stage regulates against. A start event marks the moment the supply has crossed its start threshold. From then on the block raises the reference in equal stair steps, from zero up to the code that stands for the 2.5 V target, over a fixed number of timebase ticks. The ramp length is the tick budget of the 5 ms soft-start window.

When the reference reaches its final value, the block reports that the ramp is done. It keeps the loop on the internal proportional startup controller for a fixed transition of ticks, which is the 30 ms hand-off time. After that transition it selects the external compensator.

A switching or auxiliary-activity indication is watched at every stage after the start. If no activity is seen for a window of ticks, the input line is taken as absent. The reference then drops to zero and the block waits. The first activity after that restarts the ramp from zero. A soft-start reset input returns everything to the idle state at once, and a new start event is then needed.

Top module: `softstart_ref_seq`

## Requirements
- R1: After reset the reference code is 0, the external-compensator flag (`use_ext_o`) is 0 and ramp-done is 0. Until a start event arrives, ticks and activity leave all three unchanged.
- R2: After a start event the ramp advances one step on each STEP_TICKS-th tick, where STEP_TICKS = RAMP_TICKS/STEPS. After k steps the code equals k·FINAL_CODE/STEPS, which is k·50 with the defaults.
- R3: The code reaches exactly FINAL_CODE (800 by default) on the RAMP_TICKS-th tick after the start. It never exceeds that value and then holds.
- R4: Ramp-done is 1 exactly when the ramp has completed. It rises on the same edge on which the code reaches FINAL_CODE, and whenever it is 1 the code equals FINAL_CODE.
- R5: `use_ext_o` goes from 0 (internal controller) to 1 (external compensator) on the HANDOFF_TICKS-th tick after ramp-done rises. It is never 1 while ramp-done is 0.
- R6: While the block is ramping, holding or on the external compensator, ABSENT_TICKS consecutive ticks without activity mark the line absent. On that edge the code goes to 0, ramp-done to 0 and `use_ext_o` to 0.
- R7: With the line absent, ticks change nothing. The first cycle with activity restarts the ramp from step 0.
- R8: A soft-start reset has priority over every other input. On the next edge it gives code 0, ramp-done 0 and `use_ext_o` 0, and the block waits for a new start event.
- R9: A start event that arrives while the block is ramping, holding or running has no effect on the code or the flags.
- R10: Activity in the same cycle as a tick counts as activity, so that tick does not add to the silence window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start event (supply above start threshold), one-cycle pulse |
| ss_reset_i | input | 1 | Soft-start reset, highest priority |
| tick_i | input | 1 | Timebase tick enable |
| line_act_i | input | 1 | Switching or auxiliary activity seen this cycle |
| ref_code_o | output | CODE_W | Reference code for the voltage loop |
| use_ext_o | output | 1 | 0 = internal proportional controller, 1 = external compensator |
| ramp_done_o | output | 1 | Ramp has reached its final value |

## Verification
A wrong step index or tick divider shows up on `ref_code_o` no later than the next step boundary, either as a stair level that is off by one step or as a step that comes a tick early or late. A silence counter that counts incorrectly moves the drop to zero by at least one tick, or makes it happen when it should not, for instance when a tick and activity arrive together. A faulty hand-off counter shows up as `use_ext_o` rising at the wrong tick. The bench runs a behavioural model alongside the design and compares all three outputs on every clock, so any such fault is reported in the cycle where it first reaches a port.

// File: rtl/ss_seq_pkg.sv
// Shared types for the stepped soft-start reference sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ss_seq_pkg;

    // Sequencer phases, from idle through ramp and hand-off, plus line-absent wait.
    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_RAMP = 3'd1,
        SEQ_HOLD = 3'd2,
        SEQ_RUN  = 3'd3,
        SEQ_WAIT = 3'd4
    } seq_state_t;

endpackage

// File: rtl/ss_step_timer.sv
// Stair-step generator: divides ticks into steps and turns the step index
// into a reference code equal to index * FINAL_CODE / STEPS.
// Assumes: clear_i has priority over run_i; STEP_TICKS >= 1; the index
// saturates at STEPS.
module ss_step_timer #(
    parameter int STEPS      = 16,
    parameter int STEP_TICKS = 5,
    parameter int FINAL_CODE = 800,
    parameter int CODE_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic              tick_i,
    output logic [CODE_W-1:0] code_o,
    output logic              last_step_o
);
    localparam int IDX_W     = $clog2(STEPS + 1);
    localparam int DIV_W     = $clog2(STEP_TICKS + 1);
    localparam int STEP_SIZE = FINAL_CODE / STEPS;

    logic [IDX_W-1:0] idx_q;
    logic [DIV_W-1:0] div_q;
    logic             div_wrap;

    assign div_wrap = (div_q == DIV_W'(STEP_TICKS - 1));

    // Advance the divider on ticks and the step index on each divider wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            div_q <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
            div_q <= '0;
        end else if (run_i && tick_i) begin
            if (div_wrap) begin
                div_q <= '0;
                if (idx_q != IDX_W'(STEPS))
                    idx_q <= idx_q + IDX_W'(1);
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    // Flag the tick that completes the final step.
    assign last_step_o = run_i && tick_i && div_wrap && (idx_q == IDX_W'(STEPS - 1));

    // Pick a constant-multiply or a full divide depending on step divisibility.
    generate
        if (FINAL_CODE % STEPS == 0) begin : g_even_steps
            assign code_o = CODE_W'(32'(idx_q) * 32'(STEP_SIZE));
        end else begin : g_scaled_steps
            assign code_o = CODE_W'((32'(idx_q) * 32'(FINAL_CODE)) / 32'(STEPS));
        end
    endgenerate

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> (idx_q == ($past(idx_q) + IDX_W'(1)) || idx_q == '0));

    // R2
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == ($past(idx_q) + IDX_W'(1))) |-> $past(tick_i));

    // R3
    code_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_o <= CODE_W'(FINAL_CODE));

endmodule

// File: rtl/ss_tick_window.sv
// Tick window counter: counts ticks while enabled and pulses expire_o on
// the LIMIT-th tick. Disable or clear_i restarts the count from zero.
// Used both as the line-silence detector and as the hand-off timer.
// Assumes: LIMIT >= 1; a clear in the same cycle as a tick wins.
module ss_tick_window #(
    parameter int LIMIT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clear_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count enabled ticks, restarting on disable or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i || clear_i)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Pulse on the tick that fills the window.
    assign expire_o = en_i && !clear_i && tick_i && (cnt_q == CNT_W'(LIMIT - 1));

    // R6
    window_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/softstart_ref_seq.sv
// Stepped soft-start reference sequencer, top level. Ramps the loop
// reference in stair steps after a start event, hands the loop from the
// internal startup controller to the external compensator after a fixed
// number of ticks, and restarts the ramp when line activity disappears.
// Assumes: start_i is a pulse; tick_i is a one-cycle enable; all inputs
// are synchronous to clk.
module softstart_ref_seq #(
    parameter int CODE_W        = 10,
    parameter int FINAL_CODE    = 800,
    parameter int STEPS         = 16,
    parameter int RAMP_TICKS    = 80,
    parameter int HANDOFF_TICKS = 480,
    parameter int ABSENT_TICKS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ss_reset_i,
    input  logic              tick_i,
    input  logic              line_act_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              use_ext_o,
    output logic              ramp_done_o
);
    import ss_seq_pkg::*;

    localparam int STEP_TICKS = RAMP_TICKS / STEPS;

    seq_state_t state_q, state_d;
    logic       last_step, handoff_done, line_absent;
    logic       monitoring, step_clear;

    // Register the sequencer phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // Choose the next phase; soft-start reset wins, then line loss.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: if (start_i) state_d = SEQ_RAMP;
            SEQ_RAMP: begin
                if (line_absent)    state_d = SEQ_WAIT;
                else if (last_step) state_d = SEQ_HOLD;
            end
            SEQ_HOLD: begin
                if (line_absent)       state_d = SEQ_WAIT;
                else if (handoff_done) state_d = SEQ_RUN;
            end
            SEQ_RUN:  if (line_absent) state_d = SEQ_WAIT;
            SEQ_WAIT: if (line_act_i)  state_d = SEQ_RAMP;
            default:  state_d = SEQ_IDLE;
        endcase
        if (ss_reset_i)
            state_d = SEQ_IDLE;
    end

    // Silence is watched only once the sequence is under way.
    assign monitoring = (state_q == SEQ_RAMP) || (state_q == SEQ_HOLD) || (state_q == SEQ_RUN);
    // The staircase returns to zero whenever the sequence falls back.
    assign step_clear = (state_d == SEQ_IDLE) || (state_d == SEQ_WAIT);

    ss_step_timer #(
        .STEPS      (STEPS),
        .STEP_TICKS (STEP_TICKS),
        .FINAL_CODE (FINAL_CODE),
        .CODE_W     (CODE_W)
    ) u_steps (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (step_clear),
        .run_i       (state_q == SEQ_RAMP),
        .tick_i      (tick_i),
        .code_o      (ref_code_o),
        .last_step_o (last_step)
    );

    ss_tick_window #(
        .LIMIT (ABSENT_TICKS)
    ) u_silence (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (monitoring),
        .clear_i  (line_act_i),
        .tick_i   (tick_i),
        .expire_o (line_absent)
    );

    ss_tick_window #(
        .LIMIT (HANDOFF_TICKS)
    ) u_handoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state_q == SEQ_HOLD),
        .clear_i  (1'b0),
        .tick_i   (tick_i),
        .expire_o (handoff_done)
    );

    // Flags follow the registered phase.
    assign ramp_done_o = (state_q == SEQ_HOLD) || (state_q == SEQ_RUN);
    assign use_ext_o   = (state_q == SEQ_RUN);

    // R4
    done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done_o |-> (ref_code_o == CODE_W'(FINAL_CODE)));

    // R5
    ext_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_ext_o |-> ramp_done_o);

    // R5
    ext_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_ext_o) |-> $past(tick_i));

    // R6
    absent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_absent |=> (ref_code_o == '0 && !ramp_done_o && !use_ext_o));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_WAIT && !line_act_i && !ss_reset_i) |=> (state_q == SEQ_WAIT));

    // R8
    ssr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_reset_i |=> (ref_code_o == '0 && !ramp_done_o && !use_ext_o));

endmodule

// File: tb/softstart_ref_seq_test.sv
module softstart_ref_seq_test;
    localparam int CODE_W = 10;
    localparam int FINAL  = 800;
    localparam int STEPS  = 16;
    localparam int RAMP   = 80;
    localparam int HANDO  = 480;
    localparam int ABS    = 24;
    localparam int ST     = RAMP / STEPS;

    logic clk = 0;
    logic rst_n = 0;
    logic start_i = 0, ss_reset_i = 0, tick_i = 0, line_act_i = 0;
    logic [CODE_W-1:0] ref_code_o;
    logic use_ext_o, ramp_done_o;

    int checks = 0;
    int errors = 0;
    string phase = "R1 reset";

    // Model phases: 0 idle, 1 ramp, 2 hold, 3 run, 4 wait
    int m_mode = 0, m_step = 0, m_div = 0, m_h = 0, m_s = 0;

    always #10 clk = ~clk;

    softstart_ref_seq #(
        .CODE_W(CODE_W), .FINAL_CODE(FINAL), .STEPS(STEPS),
        .RAMP_TICKS(RAMP), .HANDOFF_TICKS(HANDO), .ABSENT_TICKS(ABS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ss_reset_i(ss_reset_i),
        .tick_i(tick_i), .line_act_i(line_act_i),
        .ref_code_o(ref_code_o), .use_ext_o(use_ext_o), .ramp_done_o(ramp_done_o)
    );

    // Behavioural reference model, updated on every rising edge.
    always @(posedge clk) begin
        bit gone;
        if (!rst_n || ss_reset_i) begin
            m_mode = 0; m_step = 0; m_div = 0; m_h = 0; m_s = 0;
        end else begin
            case (m_mode)
                0: if (start_i) begin m_mode = 1; m_step = 0; m_div = 0; m_s = 0; end
                1, 2, 3: begin
                    gone = tick_i && !line_act_i && (m_s == ABS - 1);
                    if (line_act_i) m_s = 0;
                    else if (tick_i) m_s++;
                    if (gone) begin
                        m_mode = 4; m_step = 0; m_div = 0; m_h = 0; m_s = 0;
                    end else if (m_mode == 1 && tick_i) begin
                        if (m_div == ST - 1) begin
                            m_div = 0; m_step++;
                            if (m_step == STEPS) begin m_mode = 2; m_h = 0; end
                        end else m_div++;
                    end else if (m_mode == 2 && tick_i) begin
                        if (m_h == HANDO - 1) m_mode = 3;
                        else m_h++;
                    end
                end
                4: if (line_act_i) begin m_mode = 1; m_s = 0; end
                default: m_mode = 0;
            endcase
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: compare against the model, then drive new inputs.
    task automatic cyc(bit t, bit a, bit st, bit sr);
        @(negedge clk);
        chk({phase, " code"}, int'(ref_code_o), m_step * FINAL / STEPS);
        chk({phase, " done"}, int'(ramp_done_o), int'(m_mode == 2 || m_mode == 3));
        chk({phase, " ext"},  int'(use_ext_o),   int'(m_mode == 3));
        tick_i = t; line_act_i = a; start_i = st; ss_reset_i = sr;
    endtask

    task automatic run(int n, int tp, int ap);
        for (int i = 0; i < n; i++)
            cyc((i % tp) == 0, ap != 0 && (i % ap) == 0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        cyc(0, 0, 0, 0);
        chk("R1 reset code", int'(ref_code_o), 0);
        chk("R1 reset ext", int'(use_ext_o), 0);
        chk("R1 reset done", int'(ramp_done_o), 0);

        phase = "R1 idle";
        run(20, 2, 3);
        chk("R1 idle code", int'(ref_code_o), 0);

        phase = "R2 ramp";
        cyc(0, 0, 1, 0);
        run(100, 2, 3);
        chk("R2 ten steps", int'(ref_code_o), 10 * FINAL / STEPS);

        phase = "R9 start ignored";
        cyc(0, 0, 1, 0);
        phase = "R3 R4 finish";
        run(80, 2, 3);
        chk("R3 final code", int'(ref_code_o), FINAL);
        chk("R4 done", int'(ramp_done_o), 1);
        chk("R5 still internal", int'(use_ext_o), 0);

        phase = "R5 handoff";
        run(1000, 2, 3);
        chk("R5 external", int'(use_ext_o), 1);

        phase = "R6 absent";
        run(60, 2, 0);
        chk("R6 code zero", int'(ref_code_o), 0);
        chk("R6 done clear", int'(ramp_done_o), 0);
        chk("R6 internal", int'(use_ext_o), 0);

        phase = "R7 wait";
        run(30, 2, 0);
        chk("R7 waiting", int'(ref_code_o), 0);
        cyc(0, 1, 0, 0);
        run(20, 2, 3);
        chk("R7 restarted", int'(ref_code_o), 2 * FINAL / STEPS);

        phase = "R8 ss reset";
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        chk("R8 code zero", int'(ref_code_o), 0);
        run(30, 2, 3);
        chk("R8 needs start", int'(ref_code_o), 0);

        phase = "R10 coincident";
        cyc(0, 0, 1, 0);
        run(400, 2, 2);
        chk("R10 done kept", int'(ramp_done_o), 1);
        chk("R10 code", int'(ref_code_o), FINAL);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule